// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the synchronised transmit-data level and the enable of a single-wire bus driver. While the transceiver is in normal mode, it passes a low transmit level through as a dominant drive command. It refuses to let that command stay asserted without end. A free-running timebase tick paces two counters. One counter measures how long transmit-data has been low while the driver is enabled. The other measures how long transmit-data has been continuously high.

When the low time reaches its limit, the drive command is forced recessive and a timeout flag is raised. The driver is enabled again only after transmit-data has stayed high for a qualified time. That same high-time qualification is required on every entry into normal mode, so a transmit line that is low at entry can never pull the bus dominant. High is the recessive level and the idle level of an open transmit pin, so an undriven input leaves the bus released. A stuck-low input still runs into the timeout, which leaves a later change to a low-power mode possible.

Top module: `txd_dom_guard`

## Requirements
- R1: After reset, drive_dom_o and timeout_o are both 0.
- R2: drive_dom_o is 1 only while normal_i is 1, the guard is armed and txd_i is 0. With txd_i at 1 (recessive or unconnected), the command is 0.
- R3: After the guard is armed, txd_i held low for DOM_TICKS tick cycles forces drive_dom_o to 0 and sets timeout_o, both on the edge of the DOM_TICKS-th tick.
- R4: timeout_o stays set while txd_i remains low. It clears, and the guard re-arms, on the edge of the REARM_TICKS-th consecutive tick cycle with txd_i high.
- R5: A high interval shorter than REARM_TICKS ticks discards the accumulated high time. The guard stays disarmed and timeout_o stays as it was.
- R6: Each entry into normal mode starts disarmed. A low txd_i at entry never produces drive_dom_o = 1 until REARM_TICKS high ticks have passed.
- R7: With normal_i at 0, drive_dom_o is 0 at once. The next edge clears timeout_o, the arming and both counters, so accumulated high time is not carried into the next normal period.
- R8: Both counters advance only in cycles with tick_i = 1. Without ticks, neither the timeout nor the re-arm ever occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Synchronised transmit-data level, 1 = recessive/idle |
| normal_i | input | 1 | Transceiver is in normal mode |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| drive_dom_o | output | 1 | Command to drive the bus dominant |
| timeout_o | output | 1 | Dominant timeout has expired and not yet been cleared |

## Verification
Several input patterns are applied. A long low txd_i after arming shows that the release falls on exactly the DOM_TICKS-th tick and not one earlier or later. High intervals one tick short of and exactly REARM_TICKS long separate the qualified re-arm from a plain edge. Gaps with tick_i held at 0 show that time is counted in ticks and not in clocks. Leaving normal mode in the middle of a high interval, then returning with txd_i low, shows whether the high counter or the arming leaks across a mode change.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;
  typedef enum logic [1:0] {
    GUARD_IDLE    = 2'd0,
    GUARD_ARMED   = 2'd1,
    GUARD_TIMEOUT = 2'd2
  } guard_state_e;
endpackage

// File: rtl/txd_tick_cnt.sv
// Saturating tick counter; hit_o marks the LIMIT-th counted tick.
module txd_tick_cnt #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = en_i && !clr_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (en_i && cnt_q != TOP)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/txd_guard_ctrl.sv
module txd_guard_ctrl
  import txd_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic rearm_hit_i,
  input  logic dom_hit_i,
  output logic armed_o,
  output logic timeout_o
);
  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!normal_i) begin
      state_d = GUARD_IDLE;
    end else begin
      unique case (state_q)
        GUARD_IDLE:    if (rearm_hit_i) state_d = GUARD_ARMED;
        GUARD_ARMED:   if (dom_hit_i)   state_d = GUARD_TIMEOUT;
        GUARD_TIMEOUT: if (rearm_hit_i) state_d = GUARD_ARMED;
        default:                        state_d = GUARD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GUARD_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o   = (state_q == GUARD_ARMED);
  assign timeout_o = (state_q == GUARD_TIMEOUT);
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int unsigned DOM_TICKS   = 40000, // 40 ms at a 1 us tick
  parameter int unsigned REARM_TICKS = 12     // just over 10 us
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic normal_i,
  input  logic tick_i,
  output logic drive_dom_o,
  output logic timeout_o
);
  logic armed, rearm_hit, dom_hit;
  logic high_clr, high_en, low_clr, low_en;

  // high-time qualifier: any low level or mode exit discards progress
  assign high_clr = !normal_i || !txd_i;
  assign high_en  = tick_i;

  // dominant timer runs only while the driver is actually enabled
  assign low_clr  = !normal_i || txd_i || !armed;
  assign low_en   = tick_i;

  txd_tick_cnt #(.LIMIT(REARM_TICKS)) u_high_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (high_clr),
    .en_i  (high_en),
    .hit_o (rearm_hit)
  );

  txd_tick_cnt #(.LIMIT(DOM_TICKS)) u_low_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (low_clr),
    .en_i  (low_en),
    .hit_o (dom_hit)
  );

  txd_guard_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .normal_i   (normal_i),
    .rearm_hit_i(rearm_hit),
    .dom_hit_i  (dom_hit),
    .armed_o    (armed),
    .timeout_o  (timeout_o)
  );

  assign drive_dom_o = normal_i && armed && !txd_i;
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic txd_i,
  input logic normal_i,
  input logic tick_i,
  input logic drive_dom_o,
  input logic timeout_o
);
  a_r2_recessive_outside_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_i |-> !drive_dom_o);

  a_r3_timeout_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !drive_dom_o);

  a_r4_clear_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> ($past(txd_i) || !$past(normal_i)));

  a_r6_entry_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(normal_i) |-> !drive_dom_o);

  a_r7_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_i |=> !timeout_o);

  a_r8_timeout_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(tick_i) && !$past(txd_i)));
endmodule

bind txd_dom_guard txd_dom_guard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .txd_i      (txd_i),
  .normal_i   (normal_i),
  .tick_i     (tick_i),
  .drive_dom_o(drive_dom_o),
  .timeout_o  (timeout_o)
);

// File: tb/txd_dom_guard_bench.sv
module txd_dom_guard_bench;
  localparam int unsigned DOM   = 6;
  localparam int unsigned REARM = 3;

  typedef struct {
    logic  drv;
    logic  to;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1;
  logic nrm = 1'b0;
  logic tick = 1'b0;
  logic drive_dom, timeout;

  int n_chk = 0;
  int n_bad = 0;
  exp_t sb[$];
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  txd_dom_guard #(.DOM_TICKS(DOM), .REARM_TICKS(REARM)) u_txd_dom_guard (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .txd_i      (txd),
    .normal_i   (nrm),
    .tick_i     (tick),
    .drive_dom_o(drive_dom),
    .timeout_o  (timeout)
  );

  // driver: apply one cycle of inputs, queue what must be seen after the edge
  task automatic step(input logic t, input logic n, input logic k,
                      input logic ed, input logic et, input string tag);
    exp_t e;
    @(negedge clk);
    txd = t; nrm = n; tick = k;
    e.drv = ed; e.to = et; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic steps(input int cnt, input logic t, input logic n, input logic k,
                       input logic ed, input logic et, input string tag);
    for (int i = 0; i < cnt; i++) step(t, n, k, ed, et, tag);
  endtask

  // monitor: sample 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (drive_dom !== e.drv || timeout !== e.to) begin
          n_bad++;
          $display("FAIL %s: drive=%b timeout=%b, expected drive=%b timeout=%b",
                   e.tag, drive_dom, timeout, e.drv, e.to);
        end
      end
    end
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9;
    n_chk++;
    if (drive_dom !== 1'b0 || timeout !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: drive=%b timeout=%b, expected 0 0", drive_dom, timeout);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R6: enter normal with txd low, never drives
    steps(8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 entry low");
    // R2: qualify high for REARM ticks, still recessive while high
    steps(REARM, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 high recessive");
    // R2/R3: dominant for DOM-1 samples, released on the DOM-th tick
    steps(DOM - 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2 dominant");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 timeout");
    steps(4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 held low");
    // R5: short high pulse
    steps(REARM - 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 short high");
    steps(2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R5 back low");
    // R4: qualified high clears timeout on the REARM-th tick
    steps(REARM - 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 qualifying");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 cleared");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 rearmed");
    // R8: no ticks, no timeout
    steps(10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 hold no tick");
    // low timer restarted after a high cycle: full DOM again
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 high released");
    steps(DOM - 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3 count restart");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 timeout again");
    // R7: exit clears timeout
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 exit");
    steps(3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 reentry low");
    // R8: high without ticks does not qualify
    steps(5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 high no tick");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 not armed");
    // R7: partial high time does not survive a mode exit
    steps(REARM - 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 partial high");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 exit mid high");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 one high after");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 counter cleared");
    // R7: armed state does not survive a mode exit
    steps(REARM, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 arm");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2 drive");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 drive drop");
    steps(2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 reentry disarmed");

    @(negedge clk);
    tick = 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule